// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block sits between two parallel data buses, A and B, and moves data across in either direction or in both directions at once. Each direction has its own storage register with its own clock. That register takes a copy of its source bus on every rising edge of its clock. A select input then decides whether the far bus sees the live source value or the stored copy. A separate enable decides whether the far bus is driven at all.

Three-state pins are modelled as three vectors per bus: an input, an output and a per-bit output enable. Wiring a pad ring or a resolved net around the block gives the usual shared-bus behaviour. The select is not applied to the multiplexer directly. It is first registered on the capture clock of its own direction, so the multiplexer never switches in the middle of a clock period, and a select change cannot glitch the output. When both directions are enabled in live mode, each output carries the opposite input. On a resolved net, each bus then holds its own value without using the registers.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On every rising edge of `clk_ab` with `rst_n` high, the A-to-B store takes the value of `a_in`, whatever the selects and enables are.
- R2: On every rising edge of `clk_ba` with `rst_n` high, the B-to-A store takes the value of `b_in`, whatever the selects and enables are.
- R3: `sel_ab` is sampled on the rising edge of `clk_ab`. After that edge, a sampled 0 makes `b_out` follow `a_in` combinationally, and a sampled 1 makes `b_out` show the A-to-B store.
- R4: `sel_ba` is sampled on the rising edge of `clk_ba`. After that edge, a sampled 0 makes `a_out` follow `b_in`, and a sampled 1 makes `a_out` show the B-to-A store.
- R5: `b_oe` is all ones while `drv_b_en` is 1 and all zeros while it is 0 (active-high enable).
- R6: `a_oe` is all ones while `drv_a_en_n` is 0 and all zeros while it is 1 (active-low enable).
- R7: Isolation (`drv_b_en`=0, `drv_a_en_n`=1) drives neither bus, and both stores still capture on their clock edges.
- R8: With both directions enabled and both sampled selects at 0, `b_out` equals `a_in` and `a_out` equals `b_in` in the same cycle, so each bus reinforces its own value through the loop.
- R9: With both directions enabled and both sampled selects at 1, `b_out` shows the A-to-B store and `a_out` shows the B-to-A store at the same time.
- R10: A synchronous active-low `rst_n` clears each direction's store and sampled select at that direction's next clock edge. After reset, both outputs therefore carry live data until a select of 1 is sampled.
- R11: A change of `sel_ab` or `sel_ba` between clock edges leaves `b_out` and `a_out` unchanged until the next edge of the matching clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B store and its select |
| clk_ba | input | 1 | Capture clock for the B-to-A store and its select |
| rst_n | input | 1 | Synchronous active-low reset, seen by each clock |
| sel_ab | input | 1 | 0: live A to B, 1: stored A to B |
| sel_ba | input | 1 | 0: live B to A, 1: stored B to A |
| drv_b_en | input | 1 | Active-high enable for driving bus B |
| drv_a_en_n | input | 1 | Active-low enable for driving bus A |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value offered to bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value offered to bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
A corrupted store is visible at the far bus one edge after capture, but only once the sampled select is 1. The sweep therefore sets stored mode often and changes the source bus after each edge, so that live and stored values differ. A stuck or unregistered sampled select shows up at once when the select is flipped between edges: the output has to keep its earlier source until the matching clock rises. Enable faults appear at the same moment on the enable vectors, independent of any clock.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         drv_b_en,
  input  logic         drv_a_en_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [W-1:0] ab_q, ba_q;
  logic         ab_sel_q, ba_sel_q;

  always_ff @(posedge clk_ab) begin
    if (!rst_n) begin
      ab_q     <= '0;
      ab_sel_q <= 1'b0;
    end else begin
      ab_q     <= a_in;
      ab_sel_q <= sel_ab;
    end
  end

  always_ff @(posedge clk_ba) begin
    if (!rst_n) begin
      ba_q     <= '0;
      ba_sel_q <= 1'b0;
    end else begin
      ba_q     <= b_in;
      ba_sel_q <= sel_ba;
    end
  end

  assign b_out = ab_sel_q ? ab_q : a_in;
  assign a_out = ba_sel_q ? ba_q : b_in;
  assign b_oe  = {W{drv_b_en}};
  assign a_oe  = {W{~drv_a_en_n}};

  AST_AB_CAPTURE: assert property (@(posedge clk_ab) disable iff (!rst_n)
    1'b1 |=> ab_q == $past(a_in)); // R1
  AST_BA_CAPTURE: assert property (@(posedge clk_ba) disable iff (!rst_n)
    1'b1 |=> ba_q == $past(b_in)); // R2
  AST_B_STORED: assert property (@(posedge clk_ab) disable iff (!rst_n)
    sel_ab |=> b_out == $past(a_in)); // R3
  AST_B_LIVE: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !sel_ab |=> b_out == a_in); // R3
  AST_A_STORED: assert property (@(posedge clk_ba) disable iff (!rst_n)
    sel_ba |=> a_out == $past(b_in)); // R4
  AST_A_LIVE: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !sel_ba |=> a_out == b_in); // R4
  AST_B_OE_WHOLE: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_oe == '0) || (&b_oe)); // R5
  AST_A_OE_WHOLE: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (a_oe == '0) || (&a_oe)); // R6

endmodule

// File: tb/bus_xcvr_reg_tb.sv
module bus_xcvr_reg_tb_top;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk_ab = 0, clk_ba = 0, rst_n = 0;
  logic sel_ab = 0, sel_ba = 0, drv_b_en = 0, drv_a_en_n = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic m_sab = 0, m_sba = 0;

  bus_xcvr_reg #(.W(W)) dut_i (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba),
    .drv_b_en(drv_b_en), .drv_a_en_n(drv_a_en_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick_ab();
    #(CLK_PERIOD/2) clk_ab = 1;
    if (rst_n) begin m_ab = a_in; m_sab = sel_ab; end
    else begin m_ab = '0; m_sab = 0; end
    #(CLK_PERIOD/2) clk_ab = 0;
    #1;
  endtask

  task automatic tick_ba();
    #(CLK_PERIOD/2) clk_ba = 1;
    if (rst_n) begin m_ba = b_in; m_sba = sel_ba; end
    else begin m_ba = '0; m_sba = 0; end
    #(CLK_PERIOD/2) clk_ba = 0;
    #1;
  endtask

  function automatic logic [W-1:0] exp_b();
    return m_sab ? m_ab : a_in;
  endfunction
  function automatic logic [W-1:0] exp_a();
    return m_sba ? m_ba : b_in;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R10: reset with stored selects requested, outputs stay live
    rst_n = 0; sel_ab = 1; sel_ba = 1; a_in = 8'hC3; b_in = 8'h3C;
    tick_ab(); tick_ba();
    rst_n = 1; #1;
    a_in = 8'h11; b_in = 8'h22; #1;
    chk("R10 b_out live after reset", b_out, 8'h11);
    chk("R10 a_out live after reset", a_out, 8'h22);
    chk("R7 isolation b_oe", b_oe, '0);
    chk("R7 isolation a_oe", a_oe, '0);

    // R7: isolation still captures
    a_in = 8'hA5; b_in = 8'h5A; sel_ab = 1; sel_ba = 1;
    tick_ab(); tick_ba();
    a_in = 8'h00; b_in = 8'hFF; #1;
    chk("R7 stored A captured in isolation", b_out, 8'hA5);
    chk("R7 stored B captured in isolation", a_out, 8'h5A);

    // R9: both enabled, both stored
    drv_b_en = 1; drv_a_en_n = 0; #1;
    chk("R9 b_out stored", b_out, 8'hA5);
    chk("R9 a_out stored", a_out, 8'h5A);
    chk("R5 b_oe on", b_oe, '1);
    chk("R6 a_oe on", a_oe, '1);

    // R8: both enabled, both live loop
    sel_ab = 0; sel_ba = 0; tick_ab(); tick_ba();
    a_in = 8'h6E; b_in = 8'h91; #1;
    chk("R8 b_out follows a_in", b_out, 8'h6E);
    chk("R8 a_out follows b_in", a_out, 8'h91);

    // sweep: R1 R2 R3 R4 R5 R6 R11
    for (int v = 0; v < 256; v++) begin
      a_in = v[W-1:0]; b_in = v[W-1:0] ^ 8'h5A;
      sel_ab = v[0]; sel_ba = v[1]; drv_b_en = v[2]; drv_a_en_n = v[3];
      tick_ab();
      a_in = v[W-1:0] + 8'd37; #1;
      chk("R1/R3 b_out after clk_ab", b_out, exp_b());
      chk("R5 b_oe", b_oe, {W{v[2]}});
      sel_ab = ~v[0]; #1;
      chk("R11 b_out unchanged by sel_ab between edges", b_out, exp_b());
      tick_ba();
      b_in = v[W-1:0] ^ 8'hC9; #1;
      chk("R2/R4 a_out after clk_ba", a_out, exp_a());
      chk("R6 a_oe", a_oe, {W{~v[3]}});
      sel_ba = ~v[1]; #1;
      chk("R11 a_out unchanged by sel_ba between edges", a_out, exp_a());
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule